// File: doc/BRIEF.md
# PHY Test-Port Configuration Sequencer

This block loads a display PHY's internal timing and PLL registers through the PHY's narrow serial test port. A single start strobe launches a complete programming run. The block first clears the port with one pulse on the clear line, holding the PHY reset output low. It then performs a fixed series of indexed register writes: five clock-lane timing values, seven timing values for every active data lane, and six PHY/PLL configuration words. Several small PLL fields are packed into single bytes.

Each register write has two phases. In the address phase, the register index is presented with the enable line high and latched by one test-clock pulse. In the value phase, the value is presented with the enable line low and latched by a second pulse. The high and low levels of every pulse last a parameterised number of system clocks. The lane count and the parameter bundle must stay stable while `busy_o` is high. When the run ends, `done_o` pulses for one cycle and the PHY reset output is released.

Top module: `phy_cfg_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `phy_rst_n_o`, `tst_clr_o`, `tst_clk_o`, `tst_en_o` and `tst_data_o` are all zero, and the test lines stay low whenever the block is idle.
- R2: A start while idle raises `busy_o` in the next cycle. That same cycle also begins the single clear pulse on `tst_clr_o`. The clear pulse ends before the first test-clock pulse, and the two lines are never high together. `phy_rst_n_o` is low throughout the run.
- R3: Every pulse on `tst_clk_o` or `tst_clr_o` is high for exactly HI_CYC cycles and then low for LO_CYC cycles. `tst_data_o` and `tst_en_o` do not change while `tst_clk_o` is high. An address phase drives the register index with `tst_en_o` = 1.
- R4: Each address phase is followed by a value phase, with the register value on `tst_data_o` and `tst_en_o` = 0.
- R5: The first five writes target the clock lane. Write k (k = 0..4) goes to index CLK_ADDR_BASE+k, and its value is byte k of `clk_tim_i` (bits 8k+7:8k). The order is LPX, HS-prepare, HS-zero, HS-trail, wakeup.
- R6: Next, for each lane L from 0 to N-1, seven writes follow. Write j (j = 0..6) goes to index DAT_ADDR_BASE + L*LANE_STRIDE + j, and its value is byte j of `dat_tim_i`. The order is LPX, HS-prepare, HS-zero, HS-trail, TA-go, TA-get, wakeup.
- R7: Six configuration writes follow, at CFG_ADDR_BASE+0..5. Their values are:
  - the HS transmit clock select;
  - PLL word I = {2'b00, div5f, div1f, 2p[2:0], bandwidth enable};
  - the feedback P value;
  - the feedback S value;
  - PLL word IV = {pre-divide bypass, pre-divider[6:0]};
  - PLL word V = {3'd5, VCO range, loop-filter R[1:0], loop-filter C[1:0]}.
- R8: A run makes exactly 11+7N writes, where N is `lanes_i` captured at start. A value of 0 is treated as 1, and a value above MAX_LANES is treated as MAX_LANES.
- R9: A start that arrives while `busy_o` is high is ignored. It causes no second clear pulse and no change to the write stream.
- R10: `done_o` is high for exactly one cycle, the cycle right after the last value-phase pulse finishes its low level. In that cycle `busy_o` is already low and `phy_rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| lanes_i | input | 3 | Active data-lane count (1..MAX_LANES) |
| clk_tim_i | input | 40 | Clock-lane timing bytes, byte k at bits 8k+7:8k |
| dat_tim_i | input | 56 | Data-lane timing bytes, byte j at bits 8j+7:8j |
| hs_clk_sel_i | input | 8 | HS transmit clock select |
| pll_div5f_i | input | 1 | PLL feedback divide-by-5 flag |
| pll_div1f_i | input | 1 | PLL feedback divide-by-1 flag |
| pll_2p_i | input | 3 | PLL 2p field |
| pll_bw_en_i | input | 1 | PLL bandwidth enable |
| pll_fb_p_i | input | 8 | PLL feedback P value |
| pll_fb_s_i | input | 8 | PLL feedback S value |
| pll_pre_byp_i | input | 1 | PLL pre-divider bypass flag |
| pll_pre_div_i | input | 7 | PLL pre-divider value |
| pll_vco_hi_i | input | 1 | PLL VCO range flag |
| pll_lf_r_i | input | 2 | Loop-filter resistor code |
| pll_lf_c_i | input | 2 | Loop-filter capacitor code |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| phy_rst_n_o | output | 1 | PHY reset, low until a run completes |
| tst_clr_o | output | 1 | Test-port clear line |
| tst_clk_o | output | 1 | Test-port clock |
| tst_en_o | output | 1 | Test-port enable, high in address phases |
| tst_data_o | output | 8 | Test-port data: index or value |

## Verification
The assertions check on every cycle that:
- the test lines are quiet when idle;
- the clear and test-clock lines never overlap;
- every high level has the exact width;
- data and enable hold still under a high test-clock;
- the PHY reset stays low while busy;
- the done pulse is a single cycle that coincides with the release of busy and reset.

The content and order of the write stream can only be shown by the bench's scenarios, which replay the expected index/value stream for each lane count. These include the clamped lane counts, the packed PLL words, the total write count per run and the fact that a mid-run start leaves the stream untouched.

// File: rtl/phy_cfg_pkg.sv
// Package: shared widths, counts and state encodings for the PHY test-port
// configuration sequencer. Assumes an 8-bit test-data path.
package phy_cfg_pkg;
    localparam int TW    = 8;   // test-data width
    localparam int CLK_N = 5;   // clock-lane writes
    localparam int DAT_N = 7;   // writes per data lane
    localparam int CFG_N = 6;   // configuration writes
    localparam int IW    = 3;   // item index width

    typedef enum logic [1:0] {G_CLK, G_DAT, G_CFG} grp_t;
    typedef enum logic [1:0] {S_IDLE, S_CLR, S_ADDR, S_DATA} st_t;
endpackage

// File: rtl/phy_cfg_strobe.sv
// Module: phy_cfg_strobe
// Produces one pulse per go_i: HI_CYC cycles high, then LO_CYC cycles low.
// fin_o marks the last low cycle so the caller can chain the next pulse.
// Assumes go_i is only raised when no pulse is in flight.
module phy_cfg_strobe #(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic lvl_o,
    output logic fin_o
);
    localparam int MX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CW = $clog2(MX + 1);

    logic          act_q;
    logic          hi_q;
    logic [CW-1:0] cnt_q;

    // Level timer: load high count on go, then low count, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            hi_q  <= 1'b0;
            cnt_q <= '0;
        end else if (go_i) begin
            act_q <= 1'b1;
            hi_q  <= 1'b1;
            cnt_q <= CW'(HI_CYC - 1);
        end else if (act_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (hi_q) begin
                hi_q  <= 1'b0;
                cnt_q <= CW'(LO_CYC - 1);
            end else begin
                act_q <= 1'b0;
            end
        end
    end

    // Pulse level and last-low-cycle flag.
    assign lvl_o = act_q & hi_q;
    assign fin_o = act_q & ~hi_q & (cnt_q == '0);
endmodule

// File: rtl/phy_cfg_walk.sv
// Module: phy_cfg_walk
// Tracks the position in the write list as (group, lane, item): clock-lane
// items, then DAT_N items for each lane, then the configuration items.
// Assumes lanes_i is 1..MAX_LANES and stays stable after clr_i.
module phy_cfg_walk
    import phy_cfg_pkg::*;
#(
    parameter int MAX_LANES = 4,
    localparam int LW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int NW = $clog2(MAX_LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [NW-1:0] lanes_i,
    output grp_t          grp_o,
    output logic [LW-1:0] lane_o,
    output logic [IW-1:0] item_o,
    output logic          last_o
);
    logic [LW-1:0] last_lane;

    // Highest lane index of this run.
    assign last_lane = LW'(lanes_i - NW'(1));

    // Position counter: advance the item and move between groups.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            grp_o  <= G_CLK;
            lane_o <= '0;
            item_o <= '0;
        end else if (adv_i) begin
            unique case (grp_o)
                G_CLK: begin
                    if (item_o == IW'(CLK_N - 1)) begin
                        grp_o  <= G_DAT;
                        item_o <= '0;
                    end else begin
                        item_o <= item_o + 1'b1;
                    end
                end
                G_DAT: begin
                    if (item_o == IW'(DAT_N - 1)) begin
                        item_o <= '0;
                        if (lane_o == last_lane) grp_o  <= G_CFG;
                        else                     lane_o <= lane_o + 1'b1;
                    end else begin
                        item_o <= item_o + 1'b1;
                    end
                end
                default: item_o <= item_o + 1'b1;
            endcase
        end
    end

    // Final write of the list.
    assign last_o = (grp_o == G_CFG) && (item_o == IW'(CFG_N - 1));
endmodule

// File: rtl/phy_cfg_map.sv
// Module: phy_cfg_map
// Combinational map from list position to register index and value.
// Packs the PLL fields into their configuration words. Assumes the
// bundles are stable for the run.
module phy_cfg_map
    import phy_cfg_pkg::*;
#(
    parameter int            MAX_LANES     = 4,
    parameter logic [TW-1:0] CLK_ADDR_BASE = 8'h10,
    parameter logic [TW-1:0] DAT_ADDR_BASE = 8'h20,
    parameter logic [TW-1:0] LANE_STRIDE   = 8'h10,
    parameter logic [TW-1:0] CFG_ADDR_BASE = 8'h70,
    localparam int LW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  grp_t              grp_i,
    input  logic [LW-1:0]     lane_i,
    input  logic [IW-1:0]     item_i,
    input  logic [CLK_N*TW-1:0] clk_tim_i,
    input  logic [DAT_N*TW-1:0] dat_tim_i,
    input  logic [TW-1:0]     hs_clk_sel_i,
    input  logic              pll_div5f_i,
    input  logic              pll_div1f_i,
    input  logic [2:0]        pll_2p_i,
    input  logic              pll_bw_en_i,
    input  logic [TW-1:0]     pll_fb_p_i,
    input  logic [TW-1:0]     pll_fb_s_i,
    input  logic              pll_pre_byp_i,
    input  logic [6:0]        pll_pre_div_i,
    input  logic              pll_vco_hi_i,
    input  logic [1:0]        pll_lf_r_i,
    input  logic [1:0]        pll_lf_c_i,
    output logic [TW-1:0]     addr_o,
    output logic [TW-1:0]     val_o
);
    logic [TW-1:0] item_w;
    logic [TW-1:0] lane_w;
    logic [TW-1:0] cfg_val;

    assign item_w = TW'(item_i);
    assign lane_w = TW'(lane_i);

    // Configuration word for the current item.
    always_comb begin
        unique case (item_i)
            3'd0:    cfg_val = hs_clk_sel_i;
            3'd1:    cfg_val = {2'b00, pll_div5f_i, pll_div1f_i, pll_2p_i, pll_bw_en_i};
            3'd2:    cfg_val = pll_fb_p_i;
            3'd3:    cfg_val = pll_fb_s_i;
            3'd4:    cfg_val = {pll_pre_byp_i, pll_pre_div_i};
            3'd5:    cfg_val = {3'd5, pll_vco_hi_i, pll_lf_r_i, pll_lf_c_i};
            default: cfg_val = '0;
        endcase
    end

    // Index and value per group.
    always_comb begin
        unique case (grp_i)
            G_CLK: begin
                addr_o = CLK_ADDR_BASE + item_w;
                val_o  = clk_tim_i[item_i*TW +: TW];
            end
            G_DAT: begin
                addr_o = DAT_ADDR_BASE + item_w + lane_w * LANE_STRIDE;
                val_o  = dat_tim_i[item_i*TW +: TW];
            end
            default: begin
                addr_o = CFG_ADDR_BASE + item_w;
                val_o  = cfg_val;
            end
        endcase
    end
endmodule

// File: rtl/phy_cfg_seq.sv
// Module: phy_cfg_seq (top)
// Sequences a PHY test-port programming run: one clear pulse, then every
// list entry as an address phase (enable high) and a value phase (enable
// low), each latched by one test-clock pulse. Assumes the inputs are held
// stable while busy_o is high.
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter int            HI_CYC        = 2,
    parameter int            LO_CYC        = 3,
    parameter int            MAX_LANES     = 4,
    parameter logic [TW-1:0] CLK_ADDR_BASE = 8'h10,
    parameter logic [TW-1:0] DAT_ADDR_BASE = 8'h20,
    parameter logic [TW-1:0] LANE_STRIDE   = 8'h10,
    parameter logic [TW-1:0] CFG_ADDR_BASE = 8'h70,
    localparam int LW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int NW = $clog2(MAX_LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NW-1:0]       lanes_i,
    input  logic [CLK_N*TW-1:0] clk_tim_i,
    input  logic [DAT_N*TW-1:0] dat_tim_i,
    input  logic [TW-1:0]       hs_clk_sel_i,
    input  logic                pll_div5f_i,
    input  logic                pll_div1f_i,
    input  logic [2:0]          pll_2p_i,
    input  logic                pll_bw_en_i,
    input  logic [TW-1:0]       pll_fb_p_i,
    input  logic [TW-1:0]       pll_fb_s_i,
    input  logic                pll_pre_byp_i,
    input  logic [6:0]          pll_pre_div_i,
    input  logic                pll_vco_hi_i,
    input  logic [1:0]          pll_lf_r_i,
    input  logic [1:0]          pll_lf_c_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                phy_rst_n_o,
    output logic                tst_clr_o,
    output logic                tst_clk_o,
    output logic                tst_en_o,
    output logic [TW-1:0]       tst_data_o
);
    st_t           st_q;
    logic [NW-1:0] lanes_q;
    logic [NW-1:0] lanes_eff;
    logic          go, lvl, fin, launch, adv, last;
    grp_t          grp;
    logic [LW-1:0] lane;
    logic [IW-1:0] item;
    logic [TW-1:0] addr, val;

    // Clamp the requested lane count into 1..MAX_LANES.
    assign lanes_eff = (lanes_i == '0)               ? NW'(1) :
                       (lanes_i > NW'(MAX_LANES))    ? NW'(MAX_LANES) : lanes_i;

    // Pulse launch and list advance requests.
    assign launch = (st_q == S_IDLE) && start_i;
    assign adv    = (st_q == S_DATA) && fin && !last;
    assign go     = launch || (fin && (st_q != S_IDLE) && !((st_q == S_DATA) && last));

    phy_cfg_strobe #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .go_i(go), .lvl_o(lvl), .fin_o(fin)
    );

    phy_cfg_walk #(.MAX_LANES(MAX_LANES)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr_i(launch), .adv_i(adv), .lanes_i(lanes_q),
        .grp_o(grp), .lane_o(lane), .item_o(item), .last_o(last)
    );

    phy_cfg_map #(
        .MAX_LANES(MAX_LANES), .CLK_ADDR_BASE(CLK_ADDR_BASE),
        .DAT_ADDR_BASE(DAT_ADDR_BASE), .LANE_STRIDE(LANE_STRIDE),
        .CFG_ADDR_BASE(CFG_ADDR_BASE)
    ) u_map (
        .grp_i(grp), .lane_i(lane), .item_i(item),
        .clk_tim_i(clk_tim_i), .dat_tim_i(dat_tim_i), .hs_clk_sel_i(hs_clk_sel_i),
        .pll_div5f_i(pll_div5f_i), .pll_div1f_i(pll_div1f_i), .pll_2p_i(pll_2p_i),
        .pll_bw_en_i(pll_bw_en_i), .pll_fb_p_i(pll_fb_p_i), .pll_fb_s_i(pll_fb_s_i),
        .pll_pre_byp_i(pll_pre_byp_i), .pll_pre_div_i(pll_pre_div_i),
        .pll_vco_hi_i(pll_vco_hi_i), .pll_lf_r_i(pll_lf_r_i), .pll_lf_c_i(pll_lf_c_i),
        .addr_o(addr), .val_o(val)
    );

    // Phase state, lane capture, done pulse and PHY reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            lanes_q     <= NW'(1);
            done_o      <= 1'b0;
            phy_rst_n_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                S_IDLE: if (start_i) begin
                    st_q        <= S_CLR;
                    lanes_q     <= lanes_eff;
                    phy_rst_n_o <= 1'b0;
                end
                S_CLR:  if (fin) st_q <= S_ADDR;
                S_ADDR: if (fin) st_q <= S_DATA;
                default: if (fin) begin
                    if (last) begin
                        st_q        <= S_IDLE;
                        done_o      <= 1'b1;
                        phy_rst_n_o <= 1'b1;
                    end else begin
                        st_q <= S_ADDR;
                    end
                end
            endcase
        end
    end

    // Test-port line drive from phase and pulse level.
    assign busy_o     = (st_q != S_IDLE);
    assign tst_clr_o  = (st_q == S_CLR) && lvl;
    assign tst_clk_o  = ((st_q == S_ADDR) || (st_q == S_DATA)) && lvl;
    assign tst_en_o   = (st_q == S_ADDR);
    assign tst_data_o = (st_q == S_ADDR) ? addr : (st_q == S_DATA) ? val : '0;
endmodule

// File: rtl/phy_cfg_seq_chk.sv
// Module: phy_cfg_seq_chk
// Cycle-level protocol checks on the sequencer's ports, bound to phy_cfg_seq.
// Assumes HI_CYC matches the bound instance.
module phy_cfg_seq_chk #(
    parameter int HI_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic       phy_rst_n_o,
    input logic       tst_clr_o,
    input logic       tst_clk_o,
    input logic       tst_en_o,
    input logic [7:0] tst_data_o
);
    logic [31:0] hi_run;

    // Length of the current high level on either strobe line.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hi_run <= '0;
        else if (tst_clk_o || tst_clr_o) hi_run <= hi_run + 1;
        else                             hi_run <= '0;
    end

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tst_clk_o && !tst_clr_o && !tst_en_o));

    p_clr_clk_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tst_clr_o |-> !tst_clk_o);

    p_rst_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !phy_rst_n_o);

    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_clk_o && $past(tst_clk_o)) |-> ($stable(tst_data_o) && $stable(tst_en_o)));

    p_level_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_clk_o || tst_clr_o) |-> (hi_run == 32'(HI_CYC)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && phy_rst_n_o && $past(busy_o)));
endmodule

bind phy_cfg_seq phy_cfg_seq_chk #(.HI_CYC(HI_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .phy_rst_n_o(phy_rst_n_o), .tst_clr_o(tst_clr_o), .tst_clk_o(tst_clk_o),
    .tst_en_o(tst_en_o), .tst_data_o(tst_data_o)
);

// File: tb/tb_phy_cfg_seq.sv
// Scoreboard bench: the driver pushes the expected (enable, data) stream,
// the monitor pops one item per test-clock rising level and compares.
module tb_phy_cfg_seq;
    localparam int HI = 2;
    localparam int LO = 3;
    localparam logic [7:0] CB = 8'h10, DB = 8'h20, LS = 8'h10, FB = 8'h70;

    logic clk = 0, rst_n = 0, start = 0;
    logic [2:0]  lanes = 3'd1;
    logic [39:0] clk_tim = '0;
    logic [55:0] dat_tim = '0;
    logic [7:0]  hs_sel = '0, fb_p = '0, fb_s = '0;
    logic d5 = 0, d1 = 0, bw = 0, byp = 0, vco = 0;
    logic [2:0] p2 = '0;
    logic [6:0] pre = '0;
    logic [1:0] lfr = '0, lfc = '0;
    logic busy, done, prst_n, tclr, tclk, ten;
    logic [7:0] tdata;

    int checks = 0, fails = 0, cyc = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    int  clr_cnt = 0, wr_cnt = 0, exp_wr = 0, hi_run = 0;
    logic prev_clk = 0, prev_clr = 0, prev_done = 0, run_end = 0;

    always #2 clk = ~clk;   // 250 MHz

    phy_cfg_seq #(.HI_CYC(HI), .LO_CYC(LO), .MAX_LANES(4), .CLK_ADDR_BASE(CB),
                  .DAT_ADDR_BASE(DB), .LANE_STRIDE(LS), .CFG_ADDR_BASE(FB)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .lanes_i(lanes),
        .clk_tim_i(clk_tim), .dat_tim_i(dat_tim), .hs_clk_sel_i(hs_sel),
        .pll_div5f_i(d5), .pll_div1f_i(d1), .pll_2p_i(p2), .pll_bw_en_i(bw),
        .pll_fb_p_i(fb_p), .pll_fb_s_i(fb_s), .pll_pre_byp_i(byp),
        .pll_pre_div_i(pre), .pll_vco_hi_i(vco), .pll_lf_r_i(lfr), .pll_lf_c_i(lfc),
        .busy_o(busy), .done_o(done), .phy_rst_n_o(prst_n), .tst_clr_o(tclr),
        .tst_clk_o(tclk), .tst_en_o(ten), .tst_data_o(tdata));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic push_wr(input logic [7:0] a, input logic [7:0] v, input string tag);
        exp_q.push_back({1'b1, a}); tag_q.push_back(tag);
        exp_q.push_back({1'b0, v}); tag_q.push_back(tag);
    endtask

    // Driver: build expected stream from the requirements, then start a run.
    task automatic run_case(input logic [2:0] req_lanes, input logic [7:0] seed, input bit restart);
        int n;
        lanes   = req_lanes;
        clk_tim = '0; dat_tim = '0;
        for (int k = 0; k < 5; k++) clk_tim[k*8 +: 8] = seed + 8'(k);
        for (int j = 0; j < 7; j++) dat_tim[j*8 +: 8] = seed + 8'h40 + 8'(j * 3);
        hs_sel = seed ^ 8'h5A; fb_p = seed + 8'h11; fb_s = ~seed;
        d5 = seed[0]; d1 = seed[1]; p2 = seed[4:2]; bw = seed[5];
        byp = seed[6]; pre = ~seed[6:0]; vco = seed[7]; lfr = seed[3:2]; lfc = ~seed[1:0];
        n = (req_lanes == 0) ? 1 : (req_lanes > 4) ? 4 : int'(req_lanes);
        exp_wr = 11 + 7 * n;
        for (int k = 0; k < 5; k++) push_wr(CB + 8'(k), clk_tim[k*8 +: 8], "R5");
        for (int l = 0; l < n; l++)
            for (int j = 0; j < 7; j++)
                push_wr(DB + 8'(j) + 8'(l) * LS, dat_tim[j*8 +: 8], "R6");
        push_wr(FB + 8'd0, hs_sel, "R7");
        push_wr(FB + 8'd1, {2'b00, d5, d1, p2, bw}, "R7");
        push_wr(FB + 8'd2, fb_p, "R7");
        push_wr(FB + 8'd3, fb_s, "R7");
        push_wr(FB + 8'd4, {byp, pre}, "R7");
        push_wr(FB + 8'd5, {3'd5, vco, lfr, lfc}, "R7");
        clr_cnt = 0; wr_cnt = 0; run_end = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(tclr == 1'b1, "R2 clear pulse begins", tclr, 1);
        check(prst_n == 1'b0, "R2 phy reset low", prst_n, 0);
        if (restart) begin
            repeat (40) @(negedge clk);
            start = 1;                       // R9: ignored while busy
            @(negedge clk) start = 0;
        end
        while (!run_end) @(negedge clk);
        @(negedge clk);
        check(clr_cnt == 1, "R9 one clear pulse per run", clr_cnt, 1);
        check(!busy && prst_n, "R10 idle with reset released", {busy, prst_n}, 1);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each latched phase (R3 address, R4 value) in order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tclr && !prev_clr) clr_cnt++;
            if (tclk && !prev_clk) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected extra phase", {ten, tdata}, 0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    if (wr_cnt == 0 && ten) check(clr_cnt == 1, "R2 clear before first write", clr_cnt, 1);
                    check(ten == e[8], {t, " R3/R4 enable"}, ten, e[8]);
                    check(tdata == e[7:0], {t, " data"}, tdata, e[7:0]);
                    if (!ten) wr_cnt++;
                end
            end
            if (tclk || tclr) hi_run++;
            else if (prev_clk || prev_clr) begin
                check(hi_run == HI, "R3 high level width", hi_run, HI);
                hi_run = 0;
            end
            if (done) begin
                check(wr_cnt == exp_wr && exp_q.size() == 0, "R8 write count", wr_cnt, exp_wr);
                check(!busy && prst_n, "R10 done with busy low and reset high", {busy, prst_n}, 1);
                run_end = 1;
            end
            if (prev_done) check(!done, "R10 done lasts one cycle", done, 0);
        end
        prev_clk = tclk; prev_clr = tclr; prev_done = done;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(0, "R8 watchdog expired", cyc, 100000);
            report;
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !prst_n, "R1 status after reset", {busy, done, prst_n}, 0);
        check(!tclr && !tclk && !ten && tdata == 8'h00, "R1 test lines after reset",
              {tclr, tclk, ten, tdata}, 0);
        run_case(3'd1, 8'h01, 0);
        run_case(3'd2, 8'hA3, 0);
        run_case(3'd3, 8'h5C, 1);   // R9 mid-run start
        run_case(3'd4, 8'hE7, 0);
        run_case(3'd7, 8'h38, 0);   // R8 clamp high
        run_case(3'd0, 8'hC2, 0);   // R8 clamp zero
        check(!tclk && !tclr && !ten, "R1 lines quiet when idle", {tclk, tclr, ten}, 0);
        report;
        $finish;
    end
endmodule